// File: doc/BRIEF.md
# Sleep-Mode Entry and Recovery Controller

This block steps a synchronous memory into and out of a low-power sleep state under an active-high sleep request. The request may arrive from outside the clock domain, so it passes through a multi-flop synchroniser first. A small phase machine then applies a fixed entry delay and a fixed wake-up delay. Three control outputs come from that phase machine: a sleep indication, a gate that shuts off the memory's inputs, and a force that puts the memory's output drivers in high impedance.

Commands to the memory core go through the block. While the memory sleeps, every command is replaced by a deselect. During the recovery window after wake-up, reads and deselects pass unchanged. A write in that window is blocked, and a one-cycle error pulse reports it. A request that drops before the entry delay has run out cancels the entry, and the block returns straight to normal operation.

Command encoding is 2 bits: `00` deselect, `01` read, and any code with bit 1 set is a write.

Top module: `slp_ctrl`

## Requirements
- R1: During and straight after synchronous reset, `asleep`, `in_off`, `out_hiz`, `recovering` and `cmd_err` are all low.
- R2: `asleep`, `in_off` and `out_hiz` rise together at the fifth rising edge counted from the first edge that samples `sleep_req` high, provided the request stays high through the third such edge. That is 2 synchroniser cycles, 1 decision cycle and a 2-cycle entry delay.
- R3: While `asleep` is high, `cmd_o` is `00` whatever `cmd_i` carries, and `cmd_err` stays low.
- R4: `asleep`, `in_off` and `out_hiz` fall at the third rising edge counted from the first edge that samples `sleep_req` low. `recovering` is high for exactly the 2 cycles that follow, then returns low.
- R5: While `recovering` is high, a read (`01`) or deselect (`00`) on `cmd_i` appears unchanged on `cmd_o` in the same cycle.
- R6: While `recovering` is high, a write (bit 1 of `cmd_i` set) gives `cmd_o = 00` in the same cycle, and `cmd_err` is high for the one cycle after the next rising edge.
- R7: A request that is sampled high for fewer than 3 consecutive edges never raises `asleep`, and the block returns to normal operation without a recovery window.
- R8: When the block is neither asleep nor recovering, every code on `cmd_i`, writes included, passes unchanged to `cmd_o`, and `cmd_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sleep_req | input | 1 | Sleep request, active high, may be asynchronous |
| cmd_i | input | 2 | Command from the requester (00 deselect, 01 read, 1x write) |
| cmd_o | output | 2 | Command forwarded to the memory core after filtering |
| cmd_err | output | 1 | One-cycle pulse after a write blocked during recovery |
| asleep | output | 1 | Memory is in the sleep state |
| in_off | output | 1 | Disables the memory's inputs |
| out_hiz | output | 1 | Forces the memory's outputs to high impedance |
| recovering | output | 1 | Wake-up recovery window is open |

## Verification
The results arrive at different times. The sleep-state outputs change 5 edges after the request is first sampled high and 3 edges after it is first sampled low. The command filter acts in the same cycle as `cmd_i`. The error pulse follows one edge later. Each stimulus task logs the cycle index at which it drives inputs and queues every expectation at that index plus the latency from the requirement. A monitor compares queued items a short delay after each falling edge, only when the cycle index matches. The tests include the shortest request that still puts the memory to sleep (3 edges) and the two shorter requests that must cancel entry.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_ENTER = 2'd1,
        PH_SLEEP = 2'd2,
        PH_WAKE  = 2'd3
    } phase_t;

    localparam logic [1:0] OP_DESEL = 2'b00;
    localparam logic [1:0] OP_READ  = 2'b01;

    typedef struct packed {
        logic sleeping;
        logic in_off;
        logic hiz;
        logic recov;
    } ctl_t;

    function automatic logic is_write(input logic [1:0] op);
        return op[1];
    endfunction

    function automatic ctl_t ctl_of(input phase_t ph);
        ctl_t c;
        c.sleeping = (ph == PH_SLEEP);
        c.in_off   = (ph == PH_SLEEP);
        c.hiz      = (ph == PH_SLEEP);
        c.recov    = (ph == PH_WAKE);
        return c;
    endfunction

endpackage

// File: rtl/slp_sync.sv
module slp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/slp_seq.sv
module slp_seq
    import slp_pkg::*;
#(
    parameter int ENTRY_CYC = 2,
    parameter int WAKE_CYC  = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   req_s,
    output phase_t phase,
    output ctl_t   ctl
);
    localparam int MAXC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYC - 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYC - 1);

    phase_t        ph_q, ph_n;
    logic [CW-1:0] cnt_q, cnt_n;

    always_comb begin
        ph_n  = ph_q;
        cnt_n = cnt_q;
        case (ph_q)
            PH_RUN: begin
                if (req_s) begin
                    ph_n  = PH_ENTER;
                    cnt_n = '0;
                end
            end
            PH_ENTER: begin
                if (!req_s) begin
                    ph_n  = PH_RUN;
                    cnt_n = '0;
                end else if (cnt_q == ENTRY_LAST) begin
                    ph_n  = PH_SLEEP;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            PH_SLEEP: begin
                if (!req_s) begin
                    ph_n  = PH_WAKE;
                    cnt_n = '0;
                end
            end
            PH_WAKE: begin
                if (cnt_q == WAKE_LAST) begin
                    ph_n  = PH_RUN;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                ph_n  = PH_RUN;
                cnt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_RUN;
            cnt_q <= '0;
        end else begin
            ph_q  <= ph_n;
            cnt_q <= cnt_n;
        end
    end

    assign phase = ph_q;
    assign ctl   = ctl_of(ph_q);

    // R7
    abort_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_ENTER && !req_s) |=> (ph_q == PH_RUN));

    // R4
    wake_window_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_WAKE) |-> (cnt_q <= WAKE_LAST));

    // R4
    wake_after_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl.sleeping) |-> ctl.recov);
endmodule

// File: rtl/slp_gate.sv
module slp_gate
    import slp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_t     phase,
    input  logic [1:0] cmd_i,
    output logic [1:0] cmd_o,
    output logic       err
);
    logic blocked_wr;

    assign blocked_wr = (phase == PH_WAKE) && is_write(cmd_i);

    always_comb begin
        if (phase == PH_SLEEP || blocked_wr) cmd_o = OP_DESEL;
        else                                 cmd_o = cmd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= blocked_wr;
    end

    // R6
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        (err && !blocked_wr) |=> !err);
endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ENTRY_CYC   = 2,
    parameter int WAKE_CYC    = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic [1:0] cmd_i,
    output logic [1:0] cmd_o,
    output logic       cmd_err,
    output logic       asleep,
    output logic       in_off,
    output logic       out_hiz,
    output logic       recovering
);
    logic   req_s;
    phase_t phase;
    ctl_t   ctl;

    slp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sleep_req),
        .q   (req_s)
    );

    slp_seq #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .req_s (req_s),
        .phase (phase),
        .ctl   (ctl)
    );

    slp_gate u_gate (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .cmd_i (cmd_i),
        .cmd_o (cmd_o),
        .err   (cmd_err)
    );

    assign asleep     = ctl.sleeping;
    assign in_off     = ctl.in_off;
    assign out_hiz    = ctl.hiz;
    assign recovering = ctl.recov;

    // R2
    entry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(asleep) |-> ($past(req_s, 1) && $past(req_s, 2) && $past(req_s, 3)));

    // R2
    outputs_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        (asleep == in_off) && (asleep == out_hiz));

    // R3
    sleep_desel_chk: assert property (@(posedge clk) disable iff (rst)
        asleep |-> (cmd_o == OP_DESEL));

    // R6
    err_in_wake_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(recovering));
endmodule

// File: tb/sim_slp_ctrl.sv
module sim_slp_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic [1:0] cmd_o;
    logic       cmd_err, asleep, in_off, out_hiz, recovering;

    always #10 clk = ~clk;

    slp_ctrl u0 (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .cmd_i(cmd_i),
        .cmd_o(cmd_o), .cmd_err(cmd_err), .asleep(asleep), .in_off(in_off),
        .out_hiz(out_hiz), .recovering(recovering)
    );

    typedef struct {
        int         at;
        logic [6:0] mask;
        logic [6:0] val;
        string      tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    finished = 0;

    localparam logic [6:0] M_SLP = 7'h78;
    localparam logic [6:0] M_ERR = 7'h04;
    localparam logic [6:0] M_CMD = 7'h03;
    localparam logic [6:0] V_SLP = 7'h70;
    localparam logic [6:0] V_REC = 7'h08;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [6:0] obs();
        return {asleep, in_off, out_hiz, recovering, cmd_err, cmd_o};
    endfunction

    task automatic expect_at(int at, logic [6:0] m, logic [6:0] v, string tag);
        item_t it;
        it.at = at; it.mask = m; it.val = v; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic to_cyc(int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q.size() > 0 && q[0].at <= cyc) begin
                item_t it;
                logic [6:0] o;
                it = q.pop_front();
                o = obs();
                total++;
                if (it.at < cyc) begin
                    bad++;
                    $display("FAIL %s missed at cycle %0d (now %0d) actual=%b expected=%b",
                             it.tag, it.at, cyc, o & it.mask, it.val & it.mask);
                end else if ((o & it.mask) !== (it.val & it.mask)) begin
                    bad++;
                    $display("FAIL %s cycle %0d actual=%b expected=%b",
                             it.tag, cyc, o & it.mask, it.val & it.mask);
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int c;
        int d;
        @(negedge clk);
        // R1: reset state while rst is high
        expect_at(cyc, 7'h7C, 7'h00, "R1");
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        expect_at(cyc, 7'h7C, 7'h00, "R1");
        @(negedge clk);

        // R8: normal operation passes every code, no error
        c = cyc;
        cmd_i = 2'b10;
        expect_at(c, 7'h07, 7'h02, "R8");
        to_cyc(c + 1);
        cmd_i = 2'b11;
        expect_at(c + 1, 7'h07, 7'h03, "R8");
        to_cyc(c + 2);
        cmd_i = 2'b01;
        expect_at(c + 2, 7'h07, 7'h01, "R8");
        to_cyc(c + 3);
        cmd_i = 2'b00;
        expect_at(c + 3, 7'h07, 7'h00, "R8");
        to_cyc(c + 5);

        // R2: entry latency
        c = cyc;
        sleep_req = 1'b1;
        cmd_i = 2'b01;
        expect_at(c + 4, M_SLP, 7'h00, "R2");
        expect_at(c + 5, M_SLP | M_CMD, V_SLP, "R2/R3");
        to_cyc(c + 6);
        cmd_i = 2'b10;
        // R3: write while asleep is dropped, no error
        expect_at(c + 6, M_SLP | M_CMD, V_SLP, "R3");
        expect_at(c + 7, M_ERR | M_SLP, V_SLP, "R3");
        to_cyc(c + 8);
        cmd_i = 2'b00;

        // R4: exit latency and recovery window
        d = cyc;
        sleep_req = 1'b0;
        expect_at(d + 2, M_SLP, V_SLP, "R4");
        expect_at(d + 3, M_SLP | M_CMD, V_REC | 7'h01, "R4/R5");
        to_cyc(d + 3);
        cmd_i = 2'b01;
        to_cyc(d + 4);
        cmd_i = 2'b11;
        // R6: blocked write, same cycle
        expect_at(d + 4, M_SLP | M_ERR | M_CMD, V_REC, "R6");
        to_cyc(d + 5);
        cmd_i = 2'b00;
        // R6: error pulse one edge later; R4: window closed
        expect_at(d + 5, M_SLP | M_ERR, M_ERR, "R6/R4");
        expect_at(d + 6, M_ERR, 7'h00, "R6");
        to_cyc(d + 6);
        cmd_i = 2'b10;
        expect_at(d + 6, M_CMD, 7'h02, "R8");
        to_cyc(d + 7);
        cmd_i = 2'b00;
        expect_at(d + 7, M_ERR, 7'h00, "R8");
        to_cyc(d + 9);

        // R5: deselect passes during recovery
        c = cyc;
        sleep_req = 1'b1;
        to_cyc(c + 8);
        d = cyc;
        sleep_req = 1'b0;
        cmd_i = 2'b00;
        expect_at(d + 3, M_SLP | M_CMD | M_ERR, V_REC, "R5");
        expect_at(d + 4, M_SLP | M_ERR, V_REC, "R5");
        expect_at(d + 5, M_SLP, 7'h00, "R4");
        to_cyc(d + 7);

        // R7: one-cycle request pulse
        c = cyc;
        sleep_req = 1'b1;
        to_cyc(c + 1);
        sleep_req = 1'b0;
        for (int k = 3; k <= 7; k++) expect_at(c + k, M_SLP, 7'h00, "R7");
        to_cyc(c + 8);

        // R7: two-cycle request pulse
        c = cyc;
        sleep_req = 1'b1;
        to_cyc(c + 2);
        sleep_req = 1'b0;
        for (int k = 3; k <= 8; k++) expect_at(c + k, M_SLP, 7'h00, "R7");
        to_cyc(c + 9);

        // R2: three-cycle pulse is the shortest that sleeps
        c = cyc;
        sleep_req = 1'b1;
        to_cyc(c + 3);
        sleep_req = 1'b0;
        expect_at(c + 4, M_SLP, 7'h00, "R2");
        expect_at(c + 5, M_SLP, V_SLP, "R2");
        expect_at(c + 6, M_SLP, V_REC, "R4");
        expect_at(c + 7, M_SLP, V_REC, "R4");
        expect_at(c + 8, M_SLP, 7'h00, "R4");
        to_cyc(c + 10);

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule